// File: doc/BRIEF.md
# Camera Frame Capture to SRAM

This block takes one frame from a parallel CMOS camera port and stores it byte by byte in an asynchronous SRAM. The camera port has a pixel clock, a frame sync, a line-valid strobe and an 8-bit data bus. The block runs on a system clock that is much faster than the camera. It treats every camera signal as plain data. Each signal passes through a two-flop synchroniser, and a third register follows it so that edges can be found. All edge detection is done inside the system-clock domain.

A host processor pulses `start_i` to arm a capture. The block then takes over the SRAM bus and waits for frame sync to fall. From that point it accepts lines and writes one byte per pixel-clock rising edge, at incrementing addresses starting from zero. Capture ends after a set number of lines, or earlier if frame sync falls again. The block then raises `done_o` and releases the bus so the host can read the frame. A further start pulse arms capture of the next frame.

Top module: `cam_frame_capture`

## Requirements
- R1: While reset is asserted and right after it, `done_o` and `bus_oe_o` are low and `sram_ce_n_o` and `sram_we_n_o` are high.
- R2: After a start pulse, no SRAM write happens before frame sync has fallen. Line-valid pulses and pixel edges that come earlier are discarded.
- R3: A line begins on a rising edge of line-valid and ends on its falling edge. Within a line, each pixel-clock rising edge produces exactly one write, which carries the data byte present at that edge. Bytes are written in arrival order.
- R4: The SRAM address is zero for the first byte after each frame-sync fall. It rises by one for every byte written.
- R5: Each write drives chip select low with address and data valid for one cycle before write enable goes low. Write enable then stays low for exactly one cycle. Address and data do not change while write enable is low.
- R6: After LINES complete lines, the block finishes any write still in progress. It then raises `done_o` and drops `bus_oe_o`.
- R7: A frame-sync fall that comes before LINES lines are complete also ends the capture, with `done_o` raised.
- R8: While idle or done, `bus_oe_o` is low, chip select and write enable stay high, and camera activity causes no write.
- R9: A start pulse while done clears `done_o` and re-arms capture. The next frame is written again from address zero.
- R10: A start pulse during a capture is ignored, and the address sequence continues unbroken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Host pulse that arms capture |
| cam_pclk_i | input | 1 | Camera pixel clock, sampled as data |
| cam_vsync_i | input | 1 | Camera frame sync |
| cam_href_i | input | 1 | Camera line-valid strobe |
| cam_data_i | input | DW | Camera pixel byte |
| done_o | output | 1 | Frame stored; the host may own the SRAM |
| bus_oe_o | output | 1 | High while the block drives the SRAM pins |
| sram_addr_o | output | AW | SRAM address |
| sram_data_o | output | DW | SRAM write data |
| sram_ce_n_o | output | 1 | SRAM chip select, active low |
| sram_we_n_o | output | 1 | SRAM write enable, active low |
| sram_oe_n_o | output | 1 | SRAM read enable, held inactive |

## Verification
The bench uses several input patterns:
- Frames sent before any start check that an idle block ignores the camera.
- A line-valid burst while frame sync is still high checks that the block waits for the sync fall.
- A frame with a rising ramp of bytes over all lines checks byte order, the address count and the line-count ending. A start pulse placed between its lines must not disturb the address sequence.
- A second frame alternates all-ones and all-zeros bytes and is cut short by an early frame-sync fall. It shows that the address restarts at zero, that data bits are not stuck, and that the early ending works.

// File: rtl/cfc_pkg.sv
package cfc_pkg;
  typedef enum logic [2:0] {
    CAP_IDLE, CAP_ARM, CAP_WAIT_LINE, CAP_LINE, CAP_END, CAP_DONE
  } cap_state_e;

  typedef enum logic [1:0] {
    WR_IDLE, WR_STROBE, WR_HOLD
  } wr_state_e;
endpackage

// File: rtl/cfc_sync.sv
module cfc_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/cfc_edge_sync.sv
module cfc_edge_sync #(
  parameter bit RISING = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic edge_o
);
  logic lvl, lvl_d_q;

  cfc_sync #(.W(1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sig_i),
    .q_o   (lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_d_q <= 1'b0;
    else         lvl_d_q <= lvl;
  end

  generate
    if (RISING) begin : g_rise
      assign edge_o = lvl & ~lvl_d_q;
    end else begin : g_fall
      assign edge_o = ~lvl & lvl_d_q;
    end
  endgenerate
endmodule

// File: rtl/cfc_sram_writer.sv
module cfc_sram_writer
  import cfc_pkg::*;
#(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          req_i,
  input  logic [DW-1:0] data_i,
  output logic          busy_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic          ce_n_o,
  output logic          we_n_o
);
  wr_state_e st_q, st_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] dat_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      WR_IDLE:   if (req_i) st_d = WR_STROBE;
      WR_STROBE: st_d = WR_HOLD;
      WR_HOLD:   st_d = WR_IDLE;
      default:   st_d = WR_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= WR_IDLE;
      addr_q <= '0;
      dat_q  <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == WR_IDLE && req_i) dat_q <= data_i;
      if (clr_i)                    addr_q <= '0;
      else if (st_q == WR_HOLD)     addr_q <= addr_q + 1'b1;
    end
  end

  // Mealy: select and data appear in the request cycle, strobe follows
  assign ce_n_o = ~((st_q != WR_IDLE) | req_i);
  assign we_n_o = (st_q != WR_STROBE);
  assign data_o = (st_q == WR_IDLE) ? data_i : dat_q;
  assign addr_o = addr_q;
  assign busy_o = (st_q != WR_IDLE);
endmodule

// File: rtl/cfc_frame_ctrl.sv
module cfc_frame_ctrl
  import cfc_pkg::*;
#(
  parameter int LINES = 240
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic vs_fall_i,
  input  logic hr_rise_i,
  input  logic hr_fall_i,
  input  logic wr_busy_i,
  input  logic req_pend_i,
  output logic in_line_o,
  output logic addr_clr_o,
  output logic own_bus_o,
  output logic done_o
);
  localparam int LCW = $clog2(LINES) + 1;
  localparam logic [LCW-1:0] LAST_LINE = LCW'(LINES - 1);

  cap_state_e st_q, st_d;
  logic [LCW-1:0] lines_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      CAP_IDLE:      if (start_i) st_d = CAP_ARM;
      CAP_ARM:       if (vs_fall_i) st_d = CAP_WAIT_LINE;
      CAP_WAIT_LINE: begin
        if (vs_fall_i)      st_d = CAP_END;
        else if (hr_rise_i) st_d = CAP_LINE;
      end
      CAP_LINE: begin
        if (vs_fall_i)      st_d = CAP_END;
        else if (hr_fall_i) st_d = (lines_q == LAST_LINE) ? CAP_END : CAP_WAIT_LINE;
      end
      CAP_END:       if (!wr_busy_i && !req_pend_i) st_d = CAP_DONE;
      CAP_DONE:      if (start_i) st_d = CAP_ARM;
      default:       st_d = CAP_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= CAP_IDLE;
      lines_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == CAP_ARM && vs_fall_i)       lines_q <= '0;
      else if (st_q == CAP_LINE && hr_fall_i) lines_q <= lines_q + 1'b1;
    end
  end

  assign in_line_o  = (st_q == CAP_LINE);
  assign addr_clr_o = (st_q == CAP_ARM) && vs_fall_i;
  assign own_bus_o  = (st_q != CAP_IDLE) && (st_q != CAP_DONE);
  assign done_o     = (st_q == CAP_DONE);
endmodule

// File: rtl/cam_frame_capture.sv
module cam_frame_capture #(
  parameter int AW    = 17,
  parameter int DW    = 8,
  parameter int LINES = 240
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          cam_pclk_i,
  input  logic          cam_vsync_i,
  input  logic          cam_href_i,
  input  logic [DW-1:0] cam_data_i,
  output logic          done_o,
  output logic          bus_oe_o,
  output logic [AW-1:0] sram_addr_o,
  output logic [DW-1:0] sram_data_o,
  output logic          sram_ce_n_o,
  output logic          sram_we_n_o,
  output logic          sram_oe_n_o
);
  logic pclk_rise, vs_fall, hr_rise, hr_fall;
  logic [DW-1:0] data_s, pix_q;
  logic req_q, in_line, addr_clr, own_bus, wr_busy;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic wr_ce_n, wr_we_n;

  cfc_edge_sync #(.RISING(1'b1)) u_pclk_e (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(cam_pclk_i), .edge_o(pclk_rise));
  cfc_edge_sync #(.RISING(1'b0)) u_vs_e (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(cam_vsync_i), .edge_o(vs_fall));
  cfc_edge_sync #(.RISING(1'b1)) u_hr_r (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(cam_href_i), .edge_o(hr_rise));
  cfc_edge_sync #(.RISING(1'b0)) u_hr_f (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(cam_href_i), .edge_o(hr_fall));

  // Same two-flop latency as the pixel clock path keeps data aligned
  cfc_sync #(.W(DW)) u_data_s (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cam_data_i), .q_o(data_s));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_q <= '0;
      req_q <= 1'b0;
    end else begin
      req_q <= pclk_rise && in_line;
      if (pclk_rise && in_line) pix_q <= data_s;
    end
  end

  cfc_frame_ctrl #(.LINES(LINES)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .vs_fall_i (vs_fall),
    .hr_rise_i (hr_rise),
    .hr_fall_i (hr_fall),
    .wr_busy_i (wr_busy),
    .req_pend_i(req_q),
    .in_line_o (in_line),
    .addr_clr_o(addr_clr),
    .own_bus_o (own_bus),
    .done_o    (done_o)
  );

  cfc_sram_writer #(.AW(AW), .DW(DW)) u_wr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (addr_clr),
    .req_i (req_q),
    .data_i(pix_q),
    .busy_o(wr_busy),
    .addr_o(wr_addr),
    .data_o(wr_data),
    .ce_n_o(wr_ce_n),
    .we_n_o(wr_we_n)
  );

  assign bus_oe_o    = own_bus;
  assign sram_addr_o = own_bus ? wr_addr : '0;
  assign sram_data_o = own_bus ? wr_data : '0;
  assign sram_ce_n_o = wr_ce_n | ~own_bus;
  assign sram_we_n_o = wr_we_n | ~own_bus;
  assign sram_oe_n_o = 1'b1;
endmodule

// File: rtl/cfc_capture_checker.sv
module cfc_capture_checker #(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          done_o,
  input logic          bus_oe_o,
  input logic [AW-1:0] sram_addr_o,
  input logic [DW-1:0] sram_data_o,
  input logic          sram_ce_n_o,
  input logic          sram_we_n_o
);
  p_strobe_needs_select_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_n_o |-> !sram_ce_n_o);

  p_strobe_one_cycle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_n_o |=> sram_we_n_o);

  p_setup_before_strobe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sram_we_n_o) |-> ($past(!sram_ce_n_o) && $stable(sram_addr_o) && $stable(sram_data_o)));

  p_float_when_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_oe_o |-> (sram_ce_n_o && sram_we_n_o));

  p_done_releases_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !bus_oe_o);
endmodule

bind cam_frame_capture cfc_capture_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .done_o     (done_o),
  .bus_oe_o   (bus_oe_o),
  .sram_addr_o(sram_addr_o),
  .sram_data_o(sram_data_o),
  .sram_ce_n_o(sram_ce_n_o),
  .sram_we_n_o(sram_we_n_o)
);

// File: tb/cam_frame_capture_tb_top.sv
module cam_frame_capture_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int LINES = 3;
  localparam int NPIX = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, pclk = 1'b0, vsync = 1'b0, href = 1'b0;
  logic [DW-1:0] cdata = '0;
  logic done, bus_oe, ce_n, we_n, oe_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  cam_frame_capture #(.AW(AW), .DW(DW), .LINES(LINES)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .cam_pclk_i(pclk), .cam_vsync_i(vsync), .cam_href_i(href), .cam_data_i(cdata),
    .done_o(done), .bus_oe_o(bus_oe), .sram_addr_o(addr), .sram_data_o(wdata),
    .sram_ce_n_o(ce_n), .sram_we_n_o(we_n), .sram_oe_n_o(oe_n));

  typedef struct { int a; int d; } item_t;
  item_t exp_q[$];
  int n_chk = 0, n_bad = 0;
  int exp_addr = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pixel(input logic [DW-1:0] v, input bit push);
    cdata = v;
    if (push) begin
      exp_q.push_back('{a: exp_addr, d: int'(v)});
      exp_addr++;
    end
    tick(4); pclk = 1'b1; tick(4); pclk = 1'b0;
  endtask

  // pattern 0: ramp from base; pattern 1: alternating all ones / all zeros
  task automatic line(input int base, input int pat, input bit push);
    href = 1'b1; tick(4);
    for (int i = 0; i < NPIX; i++) begin
      if (pat == 0) pixel(DW'(base + i * 7), push);
      else          pixel((i % 2 == 0) ? '1 : '0, push);
    end
    tick(4); href = 1'b0; tick(8);
  endtask

  task automatic pulse_start();
    start = 1'b1; tick(1); start = 1'b0; tick(2);
  endtask

  // Monitor: scoreboard pop and write-sequence check
  logic prev_ce = 1'b1, prev_we = 1'b1;
  logic [AW-1:0] prev_addr = '0;
  logic [DW-1:0] prev_data = '0;
  always @(negedge clk) begin
    if (rst_n && !we_n) begin
      chk(prev_we == 1'b1, "R5 strobe longer than one cycle", 0, 1);
      chk(prev_ce == 1'b0 && prev_addr == addr && prev_data == wdata,
          "R5 setup cycle missing", int'(prev_ce), 0);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2/R8 unexpected write addr", int'(addr), -1);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        chk(int'(addr) == e.a, "R4 address", int'(addr), e.a);
        chk(int'(wdata) == e.d, "R3 data", int'(wdata), e.d);
      end
    end
    prev_ce = ce_n; prev_we = we_n; prev_addr = addr; prev_data = wdata;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    chk(done == 0 && bus_oe == 0 && ce_n == 1 && we_n == 1, "R1 in reset", int'(bus_oe), 0);
    rst_n = 1'b1;
    tick(3);
    chk(done == 0 && bus_oe == 0 && ce_n == 1 && we_n == 1, "R1 after reset", int'(done), 0);

    // Idle: camera traffic without start
    vsync = 1'b1; tick(6); vsync = 1'b0; tick(6);
    line(10, 0, 1'b0);
    chk(bus_oe == 0, "R8 idle bus released", int'(bus_oe), 0);

    // Frame 1: ramp data, full line count, start pulse mid-frame
    pulse_start();
    chk(bus_oe == 1, "R2 bus owned when armed", int'(bus_oe), 1);
    vsync = 1'b1; tick(6);
    line(90, 0, 1'b0);              // before sync fall: ignored (R2)
    vsync = 1'b0; tick(8);
    exp_addr = 0;
    line(1, 0, 1'b1);
    pulse_start();                  // ignored during capture (R10)
    chk(done == 0 && bus_oe == 1, "R10 start mid-frame", int'(done), 0);
    line(40, 0, 1'b1);
    line(200, 0, 1'b1);
    tick(12);
    chk(done == 1, "R6 done after line count", int'(done), 1);
    chk(bus_oe == 0, "R6 bus released at done", int'(bus_oe), 0);
    chk(exp_q.size() == 0, "R3 all bytes written", exp_q.size(), 0);
    line(77, 0, 1'b0);              // done: ignored (R8)
    chk(done == 1 && bus_oe == 0, "R8 done holds", int'(done), 1);

    // Frame 2: alternating data, early sync ends it
    pulse_start();
    chk(done == 0, "R9 start clears done", int'(done), 0);
    vsync = 1'b1; tick(6); vsync = 1'b0; tick(8);
    exp_addr = 0;                   // R9 restart at zero
    line(0, 1, 1'b1);
    line(0, 1, 1'b1);
    vsync = 1'b1; tick(6); vsync = 1'b0; tick(12);
    chk(done == 1, "R7 early sync ends capture", int'(done), 1);
    chk(bus_oe == 0, "R7 bus released", int'(bus_oe), 0);
    chk(exp_q.size() == 0, "R4 frame 2 bytes written", exp_q.size(), 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule